// File: doc/BRIEF.md
# TDM Frame Slot Sequencer

This block sets the bit and slot timing of a time-division-multiplexed serial audio frame. A serial bit-clock enable advances it by one bit at a time. A 4-bit frame code sets two things at once: the width of one slot (8 or 16 bits) and the length of the whole frame (8 to 256 bits). From its bit counter the block drives a frame sync pulse and the index of the current slot.

A transmit slot number and a receive slot number are set apart from each other. One parallel transmit word is taken through a ready/valid handshake and shifted out MSB first, only inside the transmit slot. Serial input is collected only inside the receive slot and is presented as a parallel word with a valid pulse. When the frame has 16-bit slots and at least 32 bits, a stereo option joins the chosen slot and the slot after it into one 32-bit transfer.

A new configuration is copied into the working registers only when one frame ends and the next begins. A configuration written in the middle of a frame therefore never changes that frame.

Top module: `tdm_slot_seq`

## Requirements
- R1: The frame length follows cfg_frame_code: 00xx gives 8 bits; 0100 to 0111 give 16, 32, 64 and 128 bits; 10xx gives 16 bits; 1100 to 1111 give 32, 64, 128 and 256 bits. The fsync output is high during exactly the last bit of each frame. Every registered output takes its new value on the clock edge at which bit_en is high.
- R2: When cfg_frame_code[3:2] is 00 or 10, the low two code bits have no effect.
- R3: slot_idx equals the bit position in the frame divided by the slot width. The slot width is 16 bits when cfg_frame_code[3] is 1 and 8 bits otherwise.
- R4: During the bits of the transmit slot, sdo carries the low L bits of the accepted word, MSB first. L is the slot width, or 32 bits in stereo. Outside that window sdo is 0.
- R5: A transfer is disabled when its slot number plus one (plus two in stereo) is greater than the number of slots in the frame. A disabled transmit slot keeps sdo at 0. A disabled receive slot never raises rx_valid.
- R6: Stereo is honoured only for codes 11xx. It then covers the chosen slot and the next one as a single 32-bit word, with the left channel in bits 31:16. For all other codes cfg_stereo has no effect.
- R7: The frame code, both slot numbers and cfg_stereo are sampled only on the bit that begins a new frame.
- R8: If tx_valid is low when the transmit slot begins, the block sends zeros for that slot and raises tx_underrun for one clock.
- R9: Receive bits are sampled from sdi on each bit_en edge inside the receive window. After the last bit, rx_data holds the word, zero-extended above L bits, and rx_valid is high for one clock.
- R10: tx_ready is high, combinationally, only in a clock where bit_en is high and the next bit is the first bit of an enabled transmit slot. The word is consumed in that clock when tx_valid is high.
- R11: While rst is high and after it is released, the outputs fsync, sdo, slot_idx, tx_underrun, rx_valid, rx_data and tx_ready are 0. The first bit_en after reset starts frame 0 with the configuration sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-clock enable per serial bit |
| cfg_frame_code | input | 4 | Slot width and frame length code |
| cfg_tx_slot | input | SLOT_W | Transmit slot number |
| cfg_rx_slot | input | SLOT_W | Receive slot number |
| cfg_stereo | input | 1 | Two-slot 32-bit transfer request |
| tx_data | input | WORD_W | Parallel transmit word |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| fsync | output | 1 | Frame sync, high during the last frame bit |
| slot_idx | output | SLOT_W | Current slot number |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-clock pulse with a new rx_data |
| tx_underrun | output | 1 | One-clock pulse when a slot starts without data |

## Verification
The embedded assertions check, on every cycle, four properties: fsync, tx_underrun and rx_valid are single pulses; tx_ready only occurs alongside bit_en; the working configuration stays put when no bit advances; and slot_idx never leaves the range of the active frame. Other behaviour needs the bench's scenarios and its per-clock model. That covers how each code decodes into frame and slot lengths, including the don't-care codes, and the MSB-first placement of words in the chosen slots. It also covers stereo packing, slots disabled by the frame size, zero fill on underrun, and configuration written in the middle of a frame that waits for the boundary.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  // Total bits in the frame selected by a code.
  function automatic logic [11:0] fr_bits(input logic [3:0] c);
    case (c[3:2])
      2'b00:   return 12'd8;
      2'b01:   return 12'd16 << c[1:0];
      2'b10:   return 12'd16;
      default: return 12'd32 << c[1:0];
    endcase
  endfunction

  // log2 of the slot width.
  function automatic logic [2:0] sl_shift(input logic [3:0] c);
    return c[3] ? 3'd4 : 3'd3;
  endfunction

  function automatic logic stereo_ok(input logic [3:0] c, input logic st);
    return st && c[3] && c[2];
  endfunction

  function automatic logic [5:0] xfer_len(input logic [3:0] c, input logic st);
    if (stereo_ok(c, st)) return 6'd32;
    return c[3] ? 6'd16 : 6'd8;
  endfunction

  function automatic logic [11:0] win_start(input logic [7:0] slot, input logic [3:0] c);
    return 12'(slot) << sl_shift(c);
  endfunction

  function automatic logic slot_on(input logic [7:0] slot, input logic [3:0] c, input logic st);
    logic [11:0] need;
    need = 12'(slot) + 12'(stereo_ok(c, st));
    return need < (fr_bits(c) >> sl_shift(c));
  endfunction

  function automatic logic win_hit(input logic [11:0] pos, input logic [7:0] slot,
                                   input logic [3:0] c, input logic st);
    logic [11:0] s;
    s = win_start(slot, c);
    return slot_on(slot, c, st) && (pos >= s) && (pos < s + 12'(xfer_len(c, st)));
  endfunction

endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_slot_pkg::*;
#(
  parameter int POS_W  = 8,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [3:0]        cfg_code,
  input  logic [SLOT_W-1:0] cfg_tx_slot,
  input  logic [SLOT_W-1:0] cfg_rx_slot,
  input  logic              cfg_stereo,
  output logic [POS_W-1:0]  cur_pos,
  output logic [3:0]        cur_code,
  output logic [SLOT_W-1:0] cur_rx_slot,
  output logic              cur_stereo,
  output logic [POS_W-1:0]  nxt_pos,
  output logic [3:0]        nxt_code,
  output logic [SLOT_W-1:0] nxt_tx_slot,
  output logic              nxt_stereo,
  output logic              fsync,
  output logic [SLOT_W-1:0] slot_idx
);

  logic [POS_W-1:0]  pos_q;
  logic [3:0]        code_q;
  logic [SLOT_W-1:0] txs_q, rxs_q;
  logic              st_q;
  logic              fsync_q;
  logic [SLOT_W-1:0] slot_q;
  logic              wrap;
  logic [11:0]       slot_full;

  assign wrap = (12'(pos_q) == fr_bits(code_q) - 12'd1);

  always_comb begin
    nxt_pos     = wrap ? '0 : pos_q + 1'b1;
    nxt_code    = wrap ? cfg_code : code_q;
    nxt_tx_slot = wrap ? cfg_tx_slot : txs_q;
    nxt_stereo  = wrap ? cfg_stereo : st_q;
    slot_full   = 12'(nxt_pos) >> sl_shift(nxt_code);
  end

  // Reset parks the counter on the last bit of an 8-bit frame with both
  // slots out of range, so the first bit_en opens frame 0 cleanly.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= POS_W'(7);
      code_q  <= '0;
      txs_q   <= '1;
      rxs_q   <= '1;
      st_q    <= 1'b0;
      fsync_q <= 1'b0;
      slot_q  <= '0;
    end else if (bit_en) begin
      pos_q   <= nxt_pos;
      code_q  <= nxt_code;
      txs_q   <= nxt_tx_slot;
      rxs_q   <= wrap ? cfg_rx_slot : rxs_q;
      st_q    <= nxt_stereo;
      fsync_q <= (12'(nxt_pos) == fr_bits(nxt_code) - 12'd1);
      slot_q  <= SLOT_W'(slot_full);
    end
  end

  assign cur_pos     = pos_q;
  assign cur_code    = code_q;
  assign cur_rx_slot = rxs_q;
  assign cur_stereo  = st_q;
  assign fsync       = fsync_q;
  assign slot_idx    = slot_q;

  // R1
  fsync_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (fsync_q && bit_en) |=> !fsync_q);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(code_q) && $stable(txs_q) && $stable(rxs_q) && $stable(st_q)));

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    12'(slot_q) < (fr_bits(code_q) >> sl_shift(code_q)));

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
  import tdm_slot_pkg::*;
#(
  parameter int POS_W  = 8,
  parameter int SLOT_W = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [POS_W-1:0]  nxt_pos,
  input  logic [3:0]        nxt_code,
  input  logic [SLOT_W-1:0] nxt_slot,
  input  logic              nxt_stereo,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              sdo,
  output logic              tx_underrun
);

  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] aligned;
  logic              sdo_q, und_q;
  logic              enabled, starting, in_win;
  logic [5:0]        len;

  always_comb begin
    enabled  = slot_on(8'(nxt_slot), nxt_code, nxt_stereo);
    len      = xfer_len(nxt_code, nxt_stereo);
    starting = bit_en && enabled && (12'(nxt_pos) == win_start(8'(nxt_slot), nxt_code));
    in_win   = win_hit(12'(nxt_pos), 8'(nxt_slot), nxt_code, nxt_stereo);
    aligned  = tx_valid ? (tx_data << (WORD_W - int'(len))) : '0;
  end

  assign tx_ready = starting && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      und_q <= 1'b0;
      if (bit_en) begin
        if (starting) begin
          sdo_q <= aligned[WORD_W-1];
          sh_q  <= aligned << 1;
          und_q <= !tx_valid;
        end else if (in_win) begin
          sdo_q <= sh_q[WORD_W-1];
          sh_q  <= sh_q << 1;
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign sdo         = sdo_q;
  assign tx_underrun = und_q;

  // R8
  und_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> !tx_underrun);

  // R10
  ready_en_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> bit_en);

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
  import tdm_slot_pkg::*;
#(
  parameter int POS_W  = 8,
  parameter int SLOT_W = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [POS_W-1:0]  cur_pos,
  input  logic [3:0]        cur_code,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic              cur_stereo,
  input  logic              sdi,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  logic [WORD_W-1:0] sh_q, data_q, shifted, mask;
  logic              valid_q, in_win, last_bit;
  logic [5:0]        len;

  always_comb begin
    len      = xfer_len(cur_code, cur_stereo);
    in_win   = win_hit(12'(cur_pos), 8'(cur_slot), cur_code, cur_stereo);
    last_bit = (12'(cur_pos) == win_start(8'(cur_slot), cur_code) + 12'(len) - 12'd1);
    shifted  = {sh_q[WORD_W-2:0], sdi};
    mask     = {WORD_W{1'b1}} >> (WORD_W - int'(len));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (bit_en && in_win) begin
        sh_q <= shifted;
        if (last_bit) begin
          data_q  <= shifted & mask;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;

  // R9
  rxv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
  import tdm_slot_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int WORD_W = 32,
  parameter int POS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [3:0]        cfg_frame_code,
  input  logic [SLOT_W-1:0] cfg_tx_slot,
  input  logic [SLOT_W-1:0] cfg_rx_slot,
  input  logic              cfg_stereo,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              sdi,
  output logic              sdo,
  output logic              fsync,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_underrun
);

  logic [POS_W-1:0]  cur_pos, nxt_pos;
  logic [3:0]        cur_code, nxt_code;
  logic [SLOT_W-1:0] cur_rx_slot, nxt_tx_slot;
  logic              cur_stereo, nxt_stereo;

  tdm_frame_ctr #(.POS_W(POS_W), .SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .cfg_code(cfg_frame_code), .cfg_tx_slot(cfg_tx_slot),
    .cfg_rx_slot(cfg_rx_slot), .cfg_stereo(cfg_stereo),
    .cur_pos(cur_pos), .cur_code(cur_code), .cur_rx_slot(cur_rx_slot),
    .cur_stereo(cur_stereo), .nxt_pos(nxt_pos), .nxt_code(nxt_code),
    .nxt_tx_slot(nxt_tx_slot), .nxt_stereo(nxt_stereo),
    .fsync(fsync), .slot_idx(slot_idx)
  );

  tdm_tx_path #(.POS_W(POS_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .nxt_pos(nxt_pos), .nxt_code(nxt_code), .nxt_slot(nxt_tx_slot),
    .nxt_stereo(nxt_stereo), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .sdo(sdo), .tx_underrun(tx_underrun)
  );

  tdm_rx_path #(.POS_W(POS_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .cur_pos(cur_pos), .cur_code(cur_code), .cur_slot(cur_rx_slot),
    .cur_stereo(cur_stereo), .sdi(sdi),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

endmodule

// File: tb/tdm_slot_seq_tb.sv
`timescale 1ns/1ps
module tdm_slot_seq_tb_top;
  localparam int SW = 6;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, sdi = 1'b0, tx_valid = 1'b0, cfg_stereo = 1'b0;
  logic [3:0] cfg_frame_code = '0;
  logic [SW-1:0] cfg_tx_slot = '1, cfg_rx_slot = '1;
  logic [WW-1:0] tx_data = '0;
  logic tx_ready, sdo, fsync, rx_valid, tx_underrun;
  logic [SW-1:0] slot_idx;
  logic [WW-1:0] rx_data;

  always #4 clk = ~clk;

  tdm_slot_seq #(.SLOT_W(SW), .WORD_W(WW)) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .cfg_frame_code(cfg_frame_code),
    .cfg_tx_slot(cfg_tx_slot), .cfg_rx_slot(cfg_rx_slot), .cfg_stereo(cfg_stereo),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .sdi(sdi),
    .sdo(sdo), .fsync(fsync), .slot_idx(slot_idx), .rx_data(rx_data),
    .rx_valid(rx_valid), .tx_underrun(tx_underrun)
  );

  int checks = 0, errors = 0;
  string tag = "R11";
  bit done = 0;

  // reference model state
  int mpos, mcode, mtx, mrx, m_s, m_l;
  bit mst;
  bit e_fs, e_sdo, e_und, e_rxv;
  int e_slot;
  logic [31:0] e_rxd, racc, m_w;
  bit txq[$];

  function automatic int fb(int c);
    if (c < 4) return 8;
    if (c < 8) return 8 * (2 ** (c - 3));
    if (c < 12) return 16;
    return 16 * (2 ** (c - 11));
  endfunction
  function automatic int sb(int c); return (c >= 8) ? 16 : 8; endfunction
  function automatic bit two(int c, bit st); return st && (c >= 12); endfunction
  function automatic int xl(int c, bit st); return two(c, st) ? 32 : sb(c); endfunction
  function automatic bit on(int s, int c, bit st);
    return (s + (two(c, st) ? 1 : 0)) < (fb(c) / sb(c));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mpos = 7; mcode = 0; mtx = 63; mrx = 63; mst = 0;
      e_fs = 0; e_sdo = 0; e_und = 0; e_rxv = 0; e_slot = 0;
      e_rxd = 0; racc = 0; txq.delete();
    end else begin
      e_und = 0; e_rxv = 0;
      if (bit_en) begin
        if (on(mrx, mcode, mst)) begin
          m_s = mrx * sb(mcode); m_l = xl(mcode, mst);
          if (mpos >= m_s && mpos < m_s + m_l) begin
            racc = {racc[30:0], sdi};
            if (mpos == m_s + m_l - 1) begin
              e_rxd = (m_l == 32) ? racc : (racc & ((32'd1 << m_l) - 1));
              e_rxv = 1;
            end
          end
        end
        if (mpos == fb(mcode) - 1) begin
          mpos = 0; mcode = cfg_frame_code; mtx = cfg_tx_slot;
          mrx = cfg_rx_slot; mst = cfg_stereo;
        end else mpos++;
        e_fs = (mpos == fb(mcode) - 1);
        e_slot = mpos / sb(mcode);
        e_sdo = 0;
        if (on(mtx, mcode, mst)) begin
          m_s = mtx * sb(mcode); m_l = xl(mcode, mst);
          if (mpos == m_s) begin
            m_w = tx_valid ? tx_data : 32'd0;
            e_und = !tx_valid;
            for (int i = m_l - 1; i >= 0; i--) txq.push_back(m_w[i]);
          end
          if (mpos >= m_s && mpos < m_s + m_l) e_sdo = txq.pop_front();
        end
      end
    end
  end

  function automatic bit exp_ready();
    int np, nc, nt;
    bit ns;
    if (rst || !bit_en) return 0;
    if (mpos == fb(mcode) - 1) begin
      np = 0; nc = cfg_frame_code; nt = cfg_tx_slot; ns = cfg_stereo;
    end else begin
      np = mpos + 1; nc = mcode; nt = mtx; ns = mst;
    end
    return on(nt, nc, ns) && (np == nt * sb(nc));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 fsync", fsync, e_fs);
    chk("R3 slot_idx", slot_idx, e_slot);
    chk("R4 sdo", sdo, e_sdo);
    chk("R8 tx_underrun", tx_underrun, e_und);
    chk("R9 rx_valid", rx_valid, e_rxv);
    chk("R9 rx_data", rx_data, e_rxd);
  endtask

  task automatic run(string t, int code, int txs, int rxs, bit st, int n,
                     int en_pct, int val_pct, bit rnd);
    tag = t;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
      bit_en   = (($urandom % 100) < en_pct);
      sdi      = $urandom % 2;
      tx_valid = (($urandom % 100) < val_pct);
      tx_data  = $urandom;
      if (rnd) begin
        cfg_frame_code = $urandom % 16;
        cfg_tx_slot    = $urandom % 8;
        cfg_rx_slot    = $urandom % 8;
        cfg_stereo     = $urandom % 2;
      end else begin
        cfg_frame_code = code[3:0];
        cfg_tx_slot    = txs[SW-1:0];
        cfg_rx_slot    = rxs[SW-1:0];
        cfg_stereo     = st;
      end
      #1;
      chk("R10 tx_ready", tx_ready, exp_ready());
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      compare_all();
      bit_en = 1'b1;
      #1;
      chk("R11 tx_ready in reset", tx_ready, 0);
    end
    // R11: outputs idle right after reset
    chk("R11 fsync", fsync, 0);
    chk("R11 sdo", sdo, 0);
    chk("R11 slot_idx", slot_idx, 0);
    chk("R11 rx_valid", rx_valid, 0);
    chk("R11 rx_data", rx_data, 0);
    rst = 1'b0;
    run("R11", 4'b0100, 1, 0, 0, 40, 100, 100, 0);
    run("R1", 4'b0100, 1, 0, 0, 200, 100, 100, 0);
    run("R2", 4'b0011, 0, 0, 0, 100, 100, 100, 0);
    run("R2", 4'b1001, 0, 0, 0, 150, 100, 100, 0);
    run("R1", 4'b0111, 5, 15, 0, 900, 60, 100, 0);
    run("R6", 4'b1100, 0, 0, 1, 300, 100, 100, 0);
    run("R6", 4'b1101, 2, 1, 1, 500, 80, 100, 0);
    run("R6", 4'b0110, 3, 2, 1, 300, 100, 100, 0);
    run("R5", 4'b1100, 1, 5, 1, 300, 100, 100, 0);
    run("R5", 4'b1101, 4, 3, 0, 300, 100, 100, 0);
    run("R1", 4'b1111, 15, 0, 0, 1200, 100, 100, 0);
    run("R8", 4'b0101, 2, 3, 0, 1000, 100, 50, 0);
    run("R7", 0, 0, 0, 0, 4000, 70, 80, 1);
    done = 1;
    summary();
    $finish;
  end
endmodule